// File: doc/BRIEF.md
# Dual-Port Pixel Output Demultiplexer

This block accepts one RGB pixel per clock, with 8 bits per colour by default, together with a horizontal sync input. It distributes the pixels over two output ports, A and B, according to a control byte. In single-channel operation every pixel goes to port A and port B is switched off. In dual-channel operation successive pixels go to the two ports in turn. The hardware can either present a pixel pair on both ports at once (parallel) or refresh one port per pixel (interleaved). The A/B alternation restarts on every rising edge of horizontal sync, and the starting port can be swapped.

Next to the data, the block drives a data strobe and a re-timed horizontal sync. The strobe is a clock-enable pulse at either full or half pixel rate. The sync output has a programmable active level and a programmable width in clocks. Both pass through the same register stages as the data, so their timing against the pixels never changes. No clock is gated or divided. The control values are plain inputs and are expected to be held steady while a line is streaming.

Top module: `pixel_port_demux`

## Requirements
- R1: With ctrl bit 7 = 0 (single channel), each pixel captured at clock edge n appears on port A from edge n+1, and dstrobe is high on every cycle.
- R2: In single channel, b_oe is low and port B keeps its previous value.
- R3: With ctrl bit 7 = 1 (dual channel), b_oe is high.
- R4: A rising edge of hsync_in captured at edge k makes the pixel captured at edge k+1 the first pixel of the line. The first pixel goes to port A when ctrl bit 5 = 0 and to port B when bit 5 = 1, and later pixels alternate. Holding hsync_in high does not restart the alternation.
- R5: With ctrl bit 6 = 1 (parallel) in dual channel, the two pixels of a pair appear together on both ports one edge after the second pixel is captured. Neither port changes on the other cycles. The first pixel of the pair is on A, or on B when bit 5 = 1.
- R6: With ctrl bit 6 = 0 (interleaved) in dual channel, each pixel updates exactly one port, one edge after capture, and the other port holds.
- R7: In dual channel, dstrobe is high only in the cycle in which the outputs hold the second pixel of a pair, which is half the pixel rate.
- R8: hsout goes active on the same edge that the first pixel of the line appears in interleaved or single operation, two edges after the sync edge is captured. It stays active for hs_width clocks. A hs_width of 0 produces no pulse, and a new sync edge restarts the pulse.
- R9: The active level of hsout equals hs_pol, and its idle level is the inverse.
- R10: During synchronous reset all port outputs are zero, b_oe and dstrobe are low, and hsout sits at its inactive level. The first pixel after reset goes to port A when bit 5 = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| in_r | input | CW | Red component of the incoming pixel |
| in_g | input | CW | Green component of the incoming pixel |
| in_b | input | CW | Blue component of the incoming pixel |
| hsync_in | input | 1 | Horizontal sync, rising edge is active |
| ctrl | input | 8 | Bit 7 dual channel, bit 6 parallel, bit 5 invert A/B |
| hs_pol | input | 1 | Active level of hsout |
| hs_width | input | WW | Width of hsout pulse in clocks |
| a_r | output | CW | Port A red |
| a_g | output | CW | Port A green |
| a_b | output | CW | Port A blue |
| b_r | output | CW | Port B red |
| b_g | output | CW | Port B green |
| b_b | output | CW | Port B blue |
| b_oe | output | 1 | Port B output enable (low means high impedance) |
| dstrobe | output | 1 | Data strobe, clock-enable pulse |
| hsout | output | 1 | Re-timed horizontal sync |

## Verification
A pixel captured at one edge is due on its port after the next edge. A parallel pair is due one edge after its second pixel is captured. The sync pulse starts two edges after the sync edge is captured, and the strobe follows the data exactly. The bench drives each input just after a falling edge and samples at the following falling edge. Each check therefore sees the result of exactly one rising edge, and the expected values in the vector table and in the directed tests are shifted by those one- and two-edge offsets.

// File: rtl/pdm_pkg.sv
package pdm_pkg;
  localparam int CTL_DUAL = 7;
  localparam int CTL_PAR  = 6;
  localparam int CTL_INV  = 5;

  typedef enum logic [1:0] {
    MODE_SINGLE   = 2'd0,
    MODE_DUAL_INT = 2'd1,
    MODE_DUAL_PAR = 2'd2
  } mode_e;

  function automatic mode_e decode_mode(input logic [7:0] c);
    if (!c[CTL_DUAL])    return MODE_SINGLE;
    else if (c[CTL_PAR]) return MODE_DUAL_PAR;
    else                 return MODE_DUAL_INT;
  endfunction

  function automatic logic decode_inv(input logic [7:0] c);
    return c[CTL_INV];
  endfunction
endpackage

// File: rtl/pdm_front.sv
module pdm_front #(
  parameter int PW = 24
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          hsync_in,
  input  logic [PW-1:0] pix_in,
  output logic [PW-1:0] s1_pix,
  output logic          s1_slot,
  output logic          s1_rise
);
  logic hs_prev;
  logic phase;
  logic rise;

  assign rise = hsync_in & ~hs_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      hs_prev <= 1'b0;
      phase   <= 1'b0;
      s1_pix  <= '0;
      s1_slot <= 1'b0;
      s1_rise <= 1'b0;
    end else begin
      hs_prev <= hsync_in;
      s1_pix  <= pix_in;
      s1_slot <= phase;
      s1_rise <= rise;
      phase   <= rise ? 1'b0 : ~phase;
    end
  end

  AST_HS_LEVEL_NO_RESTART: assert property (@(posedge clk) disable iff (rst)
    (hs_prev && hsync_in) |=> (phase != $past(phase))); // R4

  AST_EDGE_GIVES_FIRST: assert property (@(posedge clk) disable iff (rst)
    rise |=> ##1 (s1_slot == 1'b0)); // R4
endmodule

// File: rtl/pdm_steer.sv
module pdm_steer
  import pdm_pkg::*;
#(
  parameter int PW = 24
) (
  input  logic          clk,
  input  logic          rst,
  input  mode_e         mode,
  input  logic          inv,
  input  logic [PW-1:0] s1_pix,
  input  logic          s1_slot,
  output logic [PW-1:0] pa,
  output logic [PW-1:0] pb,
  output logic          pb_oe,
  output logic          stb
);
  logic [PW-1:0] hold;

  always_ff @(posedge clk) begin
    if (rst) begin
      pa    <= '0;
      pb    <= '0;
      hold  <= '0;
      pb_oe <= 1'b0;
      stb   <= 1'b0;
    end else begin
      pb_oe <= (mode != MODE_SINGLE);
      case (mode)
        MODE_DUAL_INT: begin
          stb <= s1_slot;
          if (s1_slot ^ inv) pb <= s1_pix;
          else               pa <= s1_pix;
        end
        MODE_DUAL_PAR: begin
          stb <= s1_slot;
          if (!s1_slot) begin
            hold <= s1_pix;
          end else if (inv) begin
            pa <= s1_pix;
            pb <= hold;
          end else begin
            pa <= hold;
            pb <= s1_pix;
          end
        end
        default: begin
          stb <= 1'b1;
          pa  <= s1_pix;
        end
      endcase
    end
  end

  AST_SINGLE_B_OFF: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_SINGLE) |=> (!pb_oe && $stable(pb))); // R2

  AST_SINGLE_FULL_RATE: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_SINGLE) |=> stb); // R1

  AST_DUAL_B_ON: assert property (@(posedge clk) disable iff (rst)
    (mode != MODE_SINGLE) |=> pb_oe); // R3

  AST_PAR_HOLD_FIRST: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_DUAL_PAR && !s1_slot) |=> ($stable(pa) && $stable(pb) && !stb)); // R5

  AST_INT_ONE_PORT: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_DUAL_INT) |=> ($stable(pa) || $stable(pb))); // R6
endmodule

// File: rtl/pdm_hsync.sv
module pdm_hsync #(
  parameter int WW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rise_in,
  input  logic          pol,
  input  logic [WW-1:0] width,
  output logic          hsout
);
  logic          hs_d;
  logic [WW-1:0] cnt;
  logic [WW-1:0] cnt_nx;

  always_comb begin
    if (hs_d)            cnt_nx = width;
    else if (cnt != '0)  cnt_nx = cnt - 1'b1;
    else                 cnt_nx = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hs_d  <= 1'b0;
      cnt   <= '0;
      hsout <= ~pol;
    end else begin
      hs_d  <= rise_in;
      cnt   <= cnt_nx;
      hsout <= (cnt_nx != '0) ? pol : ~pol;
    end
  end

  AST_HS_START: assert property (@(posedge clk) disable iff (rst)
    (hs_d && width != '0) |=> (hsout == $past(pol))); // R8

  AST_HS_ZERO_WIDTH: assert property (@(posedge clk) disable iff (rst)
    (hs_d && width == '0) |=> (hsout == !$past(pol))); // R8

  AST_HS_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!hs_d && cnt == '0) |=> (hsout == !$past(pol))); // R9
endmodule

// File: rtl/pixel_port_demux.sv
module pixel_port_demux
  import pdm_pkg::*;
#(
  parameter int CW = 8,
  parameter int WW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] in_r,
  input  logic [CW-1:0] in_g,
  input  logic [CW-1:0] in_b,
  input  logic          hsync_in,
  input  logic [7:0]    ctrl,
  input  logic          hs_pol,
  input  logic [WW-1:0] hs_width,
  output logic [CW-1:0] a_r,
  output logic [CW-1:0] a_g,
  output logic [CW-1:0] a_b,
  output logic [CW-1:0] b_r,
  output logic [CW-1:0] b_g,
  output logic [CW-1:0] b_b,
  output logic          b_oe,
  output logic          dstrobe,
  output logic          hsout
);
  localparam int PW = 3 * CW;

  mode_e         mode;
  logic          inv;
  logic [PW-1:0] s1_pix;
  logic          s1_slot;
  logic          s1_rise;
  logic [PW-1:0] pa;
  logic [PW-1:0] pb;

  assign mode = decode_mode(ctrl);
  assign inv  = decode_inv(ctrl);

  pdm_front #(.PW(PW)) u_front (
    .clk(clk), .rst(rst), .hsync_in(hsync_in), .pix_in({in_r, in_g, in_b}),
    .s1_pix(s1_pix), .s1_slot(s1_slot), .s1_rise(s1_rise)
  );

  pdm_steer #(.PW(PW)) u_steer (
    .clk(clk), .rst(rst), .mode(mode), .inv(inv), .s1_pix(s1_pix),
    .s1_slot(s1_slot), .pa(pa), .pb(pb), .pb_oe(b_oe), .stb(dstrobe)
  );

  pdm_hsync #(.WW(WW)) u_hsync (
    .clk(clk), .rst(rst), .rise_in(s1_rise), .pol(hs_pol), .width(hs_width),
    .hsout(hsout)
  );

  assign {a_r, a_g, a_b} = pa;
  assign {b_r, b_g, b_b} = pb;

  AST_RESET_CLEAN: assert property (@(posedge clk)
    rst |=> (pa == '0 && pb == '0 && !b_oe && !dstrobe)); // R10

  AST_DUAL_HALF_RATE: assert property (@(posedge clk) disable iff (rst)
    (mode != MODE_SINGLE && $past(mode) != MODE_SINGLE && dstrobe) |=> !dstrobe); // R7
endmodule

// File: tb/pixel_port_demux_test.sv
`timescale 1ns/1ps
module pixel_port_demux_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] in_r = 8'd0, in_g = 8'd0, in_b = 8'd0;
  logic       hsync_in = 1'b0;
  logic [7:0] ctrl = 8'h80;
  logic       hs_pol = 1'b1;
  logic [7:0] hs_width = 8'd2;
  logic [7:0] a_r, a_g, a_b, b_r, b_g, b_b;
  logic       b_oe, dstrobe, hsout;

  int errs = 0;
  int checks = 0;
  logic [23:0] b_keep;

  always #10 clk = ~clk;

  pixel_port_demux uut (
    .clk(clk), .rst(rst), .in_r(in_r), .in_g(in_g), .in_b(in_b),
    .hsync_in(hsync_in), .ctrl(ctrl), .hs_pol(hs_pol), .hs_width(hs_width),
    .a_r(a_r), .a_g(a_g), .a_b(a_b), .b_r(b_r), .b_g(b_g), .b_b(b_b),
    .b_oe(b_oe), .dstrobe(dstrobe), .hsout(hsout)
  );

  // row: hs, pixel tag, expected A tag, expected B tag, strobe, hsout (0 tag = all zero)
  localparam logic [26:0] TBL [0:10] = '{
    {1'b0, 8'h10, 8'h00, 8'h00, 1'b0, 1'b0},
    {1'b1, 8'h11, 8'h10, 8'h00, 1'b0, 1'b0},
    {1'b1, 8'h12, 8'h10, 8'h11, 1'b1, 1'b0},
    {1'b0, 8'h13, 8'h12, 8'h11, 1'b0, 1'b1},
    {1'b0, 8'h14, 8'h12, 8'h13, 1'b1, 1'b1},
    {1'b0, 8'h15, 8'h14, 8'h13, 1'b0, 1'b0},
    {1'b1, 8'h16, 8'h14, 8'h15, 1'b1, 1'b0},
    {1'b0, 8'h17, 8'h16, 8'h15, 1'b0, 1'b0},
    {1'b0, 8'h18, 8'h17, 8'h15, 1'b0, 1'b1},
    {1'b0, 8'h19, 8'h17, 8'h18, 1'b1, 1'b1},
    {1'b0, 8'h1A, 8'h19, 8'h18, 1'b0, 1'b0}
  };

  function automatic logic [23:0] pv(input logic [7:0] v);
    return (v == 8'h00) ? 24'h0 : {v, ~v, v + 8'd3};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input logic hs, input logic [7:0] v);
    hsync_in = hs;
    in_r = v; in_g = ~v; in_b = v + 8'd3;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(20 * 100000);
    errs++;
    $display("FAIL watchdog act=hung exp=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    @(negedge clk);
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10 reset A", {a_r, a_g, a_b}, 0);
    chk("R10 reset B", {b_r, b_g, b_b}, 0);
    chk("R10 reset oe/stb", {b_oe, dstrobe}, 0);
    chk("R10 reset hsout idle", hsout, 0);
    rst = 1'b0;

    // Vector table: dual interleaved, no invert, width 2, active high (R4 R6 R7 R8)
    for (int i = 0; i <= 10; i++) begin
      step(TBL[i][26], TBL[i][25:18]);
      chk($sformatf("R6 row%0d A", i), {a_r, a_g, a_b}, pv(TBL[i][17:10]));
      chk($sformatf("R4 row%0d B", i), {b_r, b_g, b_b}, pv(TBL[i][9:2]));
      chk($sformatf("R7 row%0d strobe", i), dstrobe, TBL[i][1]);
      chk($sformatf("R8 row%0d hsout", i), hsout, TBL[i][0]);
    end
    chk("R3 dual oe", b_oe, 1);

    // R1 R2: single channel
    b_keep = {b_r, b_g, b_b};
    ctrl = 8'h00;
    step(1'b0, 8'h50);
    step(1'b0, 8'h51);
    chk("R1 single A", {a_r, a_g, a_b}, pv(8'h50));
    chk("R1 single strobe", dstrobe, 1);
    chk("R2 single oe", b_oe, 0);
    step(1'b0, 8'h52);
    chk("R1 single A next", {a_r, a_g, a_b}, pv(8'h51));
    chk("R2 single B held", {b_r, b_g, b_b}, b_keep);

    // R5: parallel, no invert
    ctrl = 8'hC0;
    step(1'b0, 8'h1F);
    step(1'b1, 8'h20);
    step(1'b0, 8'h21);
    step(1'b0, 8'h22);
    chk("R5 par first pending strobe", dstrobe, 0);
    b_keep = {a_r, a_g, a_b};
    step(1'b0, 8'h23);
    chk("R5 par A", {a_r, a_g, a_b}, pv(8'h21));
    chk("R5 par B", {b_r, b_g, b_b}, pv(8'h22));
    chk("R7 par strobe", dstrobe, 1);
    step(1'b0, 8'h24);
    chk("R5 par A held", {a_r, a_g, a_b}, pv(8'h21));
    step(1'b0, 8'h25);
    chk("R5 par pair2", {a_r, a_g, a_b, b_r, b_g, b_b}, {pv(8'h23), pv(8'h24)});

    // R5 R4: parallel with invert
    ctrl = 8'hE0;
    step(1'b0, 8'h2F);
    step(1'b1, 8'h40);
    step(1'b0, 8'h41);
    step(1'b0, 8'h42);
    step(1'b0, 8'h43);
    chk("R5 par inv", {a_r, a_g, a_b, b_r, b_g, b_b}, {pv(8'h42), pv(8'h41)});

    // R4: interleaved with invert, first pixel on B
    ctrl = 8'hA0;
    step(1'b0, 8'h2E);
    step(1'b1, 8'h30);
    step(1'b0, 8'h31);
    step(1'b0, 8'h32);
    chk("R4 inv first on B", {b_r, b_g, b_b}, pv(8'h31));
    step(1'b0, 8'h33);
    chk("R4 inv second on A", {a_r, a_g, a_b}, pv(8'h32));

    // R9 R8: active-low sync, width 3
    ctrl = 8'h80; hs_pol = 1'b0; hs_width = 8'd3;
    step(1'b0, 8'h60);
    step(1'b1, 8'h61);
    step(1'b0, 8'h62);
    chk("R9 idle high", hsout, 1);
    step(1'b0, 8'h63);
    chk("R9 active low 1", hsout, 0);
    step(1'b0, 8'h64);
    chk("R8 active low 2", hsout, 0);
    step(1'b0, 8'h65);
    chk("R8 active low 3", hsout, 0);
    step(1'b0, 8'h66);
    chk("R8 pulse ended", hsout, 1);

    // R8: zero width gives no pulse
    hs_width = 8'd0;
    step(1'b1, 8'h67);
    for (int j = 0; j < 4; j++) begin
      step(1'b0, 8'h68);
      chk("R8 zero width", hsout, 1);
    end

    // R10: reset with active-low polarity
    rst = 1'b1;
    step(1'b0, 8'h70);
    step(1'b0, 8'h71);
    chk("R10 reset hsout low pol", hsout, 1);
    chk("R10 reset ports", {a_r, a_g, a_b, b_r, b_g, b_b, b_oe, dstrobe}, 0);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule